// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Gated Status Flags

This block is the arithmetic core of a small multi-cycle processor. It combines two 8-bit operands according to a 4-bit operation code. The data result appears combinationally in the same cycle the inputs are applied. Alongside the result it forms four condition bits: zero, carry, negative and overflow.

The four condition bits are not exposed directly. They pass through a status register that loads only when the control sequencer raises the update enable, which it does as an ALU-class instruction completes. Because of this, a memory access or a branch placed between a compare and a conditional branch leaves the compare outcome intact.

Subtraction reuses the adder. The second operand is inverted and a carry-in of one is injected, so one carry chain serves both add and subtract.

Top module: `alu_flagged`

## Requirements
- R1: Code 0 (add) gives result = (A + B) mod 256, carry = unsigned carry out of bit 7, and overflow = 1 when the signed sum lies outside -128..127.
- R2: Code 1 (subtract) gives result = (A + ~B + 1) mod 256, carry = 1 when A >= B unsigned (no borrow), and overflow = 1 when the signed difference A - B lies outside -128..127.
- R3: Codes 2 (AND), 3 (OR), 4 (XOR) and 5 (NOT of A) give the bitwise result, with carry and overflow cleared.
- R4: Code 6 shifts A left by one and code 7 shifts A right by one (logical), filling the vacated bit with zero. Carry takes the bit shifted out (bit 7 for left, bit 0 for right) and overflow is cleared.
- R5: Code 8 passes B to the result unchanged, with carry and overflow cleared.
- R6: On a flag update, zero is set exactly when the 8-bit result is 0, and negative equals result bit 7.
- R7: The flag outputs load on the rising clock edge where the update enable is 1 and hold their value on every edge where it is 0.
- R8: Codes 9 to 15 give a zero result and leave all four flags unchanged, even when the update enable is 1.
- R9: An active-low reset clears all four flag outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the status register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| op_sel | input | 4 | Operation code |
| flag_en | input | 1 | Load the status register this cycle |
| result | output | 8 | Combinational result |
| flag_z | output | 1 | Latched zero flag |
| flag_c | output | 1 | Latched carry flag |
| flag_n | output | 1 | Latched negative flag |
| flag_v | output | 1 | Latched overflow flag |

## Verification
The result is due in the same cycle as its inputs. The flags are due one rising edge after the operation is presented with the enable high. The bench applies each stimulus on the falling edge and compares the result 1 ns later, still before the next rising edge. It then compares the flags 1 ns after that rising edge against a reference model, which updates its own flag copy only when the enable was high and the code was defined. Directed corner cases are covered: signed overflow in both directions, borrow, zero results, shift-out bits, undefined codes issued with the enable set, and a disabled update placed between a compare and a later read. A long randomized run follows the directed cases.

// File: rtl/alu_flagged.sv
module alu_flagged #(
  parameter int W   = 8,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [OPW-1:0] op_sel,
  input  logic           flag_en,
  output logic [W-1:0]   result,
  output logic           flag_z,
  output logic           flag_c,
  output logic           flag_n,
  output logic           flag_v
);
  localparam logic [OPW-1:0] OP_ADD  = OPW'(0);
  localparam logic [OPW-1:0] OP_SUB  = OPW'(1);
  localparam logic [OPW-1:0] OP_AND  = OPW'(2);
  localparam logic [OPW-1:0] OP_OR   = OPW'(3);
  localparam logic [OPW-1:0] OP_XOR  = OPW'(4);
  localparam logic [OPW-1:0] OP_NOT  = OPW'(5);
  localparam logic [OPW-1:0] OP_SHL  = OPW'(6);
  localparam logic [OPW-1:0] OP_SHR  = OPW'(7);
  localparam logic [OPW-1:0] OP_PASS = OPW'(8);

  logic         is_sub;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic         add_ovf;
  logic         c_nxt, v_nxt, op_ok;

  assign is_sub  = (op_sel == OP_SUB);
  assign b_eff   = is_sub ? ~opnd_b : opnd_b;
  assign sum     = {1'b0, opnd_a} + {1'b0, b_eff} + (W+1)'(is_sub);
  assign add_ovf = (opnd_a[W-1] == b_eff[W-1]) && (sum[W-1] != opnd_a[W-1]);

  always_comb begin
    result = '0;
    c_nxt  = 1'b0;
    v_nxt  = 1'b0;
    op_ok  = 1'b1;
    case (op_sel)
      OP_ADD, OP_SUB: begin
        result = sum[W-1:0];
        c_nxt  = sum[W];
        v_nxt  = add_ovf;
      end
      OP_AND:  result = opnd_a & opnd_b;
      OP_OR:   result = opnd_a | opnd_b;
      OP_XOR:  result = opnd_a ^ opnd_b;
      OP_NOT:  result = ~opnd_a;
      OP_SHL: begin
        result = {opnd_a[W-2:0], 1'b0};
        c_nxt  = opnd_a[W-1];
      end
      OP_SHR: begin
        result = {1'b0, opnd_a[W-1:1]};
        c_nxt  = opnd_a[0];
      end
      OP_PASS: result = opnd_b;
      default: op_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      flag_n <= 1'b0;
      flag_v <= 1'b0;
    end else if (flag_en && op_ok) begin
      flag_z <= (result == '0);
      flag_c <= c_nxt;
      flag_n <= result[W-1];
      flag_v <= v_nxt;
    end
  end
endmodule

// File: rtl/alu_flagged_chk.sv
module alu_flagged_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] opnd_a,
  input logic [7:0] opnd_b,
  input logic [3:0] op_sel,
  input logic       flag_en,
  input logic [7:0] result,
  input logic       flag_z,
  input logic       flag_c,
  input logic       flag_n,
  input logic       flag_v
);
  logic [3:0] flags;
  assign flags = {flag_z, flag_c, flag_n, flag_v};

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> $stable(flags));

  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 4'd8) |-> (result == 8'd0));

  // R8
  unused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 4'd8) |=> $stable(flags));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && op_sel <= 4'd8) |=> (flag_z == ($past(result) == 8'd0)));

  // R6
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && op_sel <= 4'd8) |=> (flag_n == $past(result[7])));

  // R3
  logic_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && ((op_sel >= 4'd2 && op_sel <= 4'd5) || op_sel == 4'd8)) |=> (!flag_c && !flag_v));

  // R2
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && op_sel == 4'd1) |=> (flag_c == ($past(opnd_a) >= $past(opnd_b))));
endmodule

bind alu_flagged alu_flagged_chk u_chk (.*);

// File: tb/alu_flagged_bench.sv
`timescale 1ns/1ps
module alu_flagged_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic [3:0] op_sel = '0;
  logic       flag_en = 1'b0;
  logic [7:0] result;
  logic       flag_z, flag_c, flag_n, flag_v;

  int  checks = 0, fails = 0;
  bit  mz = 0, mc = 0, mn = 0, mv = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  alu_flagged u_alu_flagged (.*);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(int op);
    if (op == 0) return "R1";
    if (op == 1) return "R2";
    if (op <= 5) return "R3";
    if (op <= 7) return "R4";
    if (op == 8) return "R5";
    return "R8";
  endfunction

  function automatic void model(int a, int b, int op, output int r, output bit c,
                                output bit v, output bit ok);
    int sa, sb, s;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    ok = 1; c = 0; v = 0; r = 0;
    case (op)
      0: begin r = (a + b) % 256; c = (a + b) > 255; s = sa + sb; v = (s > 127) || (s < -128); end
      1: begin r = (a - b + 256) % 256; c = (a >= b); s = sa - sb; v = (s > 127) || (s < -128); end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = 255 - a;
      6: begin r = (a * 2) % 256; c = (a >= 128); end
      7: begin r = a / 2; c = (a % 2) == 1; end
      8: r = b;
      default: ok = 0;
    endcase
  endfunction

  task automatic step(int a, int b, int op, bit en);
    int r; bit c, v, ok; string t;
    @(negedge clk);
    opnd_a = 8'(a); opnd_b = 8'(b); op_sel = 4'(op); flag_en = en;
    #1;
    model(a, b, op, r, c, v, ok);
    chk(result == 8'(r), tag_of(op), "result", result, r);
    @(posedge clk); #1;
    if (en && ok) begin
      mz = (r == 0); mn = (r >= 128); mc = c; mv = v;
      chk({flag_z, flag_n} == {mz, mn}, "R6", "zn", {flag_z, flag_n}, {mz, mn});
    end
    t = !ok ? "R8" : (!en ? "R7" : tag_of(op));
    chk({flag_z, flag_c, flag_n, flag_v} == {mz, mc, mn, mv}, t, "flags zcnv",
        {flag_z, flag_c, flag_n, flag_v}, {mz, mc, mn, mv});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({flag_z, flag_c, flag_n, flag_v} == 4'b0, "R9", "reset flags",
        {flag_z, flag_c, flag_n, flag_v}, 0);
    @(negedge clk); rst_n = 1'b1;
    // R1 signed overflow into negative, carry out with zero result
    step(8'h7F, 8'h01, 0, 1);
    step(8'hFF, 8'h01, 0, 1);
    step(8'h80, 8'h80, 0, 1);
    // R2 equal, borrow, negative overflow
    step(5, 5, 1, 1);
    step(3, 5, 1, 1);
    step(8'h80, 1, 1, 1);
    step(8'h7F, 8'hFF, 1, 1);
    // R7 compare, then disabled update (load between compare and branch)
    step(9, 4, 1, 1);
    step(0, 0, 8, 0);
    step(8'hF0, 8'h0F, 0, 0);
    // R3 logic clears C and V after a carry-setting op
    step(8'hFF, 8'h01, 0, 1);
    step(8'hF0, 8'h3C, 2, 1);
    step(8'hF0, 8'h0F, 3, 1);
    step(8'hAA, 8'hAA, 4, 1);
    step(8'h00, 8'h00, 5, 1);
    // R4 shifts and shifted-out bit
    step(8'h81, 0, 6, 1);
    step(8'h80, 0, 6, 1);
    step(8'h01, 0, 7, 1);
    step(8'hFE, 0, 7, 1);
    // R5 pass-through of B
    step(8'h12, 8'h9A, 8, 1);
    step(8'h12, 8'h00, 8, 1);
    // R8 undefined codes with enable set
    step(8'hFF, 8'h01, 0, 1);
    for (int op = 9; op < 16; op++) step(8'h55, 8'h00, op, 1);
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 15),
           $urandom_range(0, 3) != 0);
    finish_run();
  end
endmodule